// File: doc/BRIEF.md
# Interrupt Status Latch and Mask Controller

This block gathers three event sources from a digital audio transmitter into two read-only status registers. The sources are a source-sample slip, a channel-status buffer transfer and a user-data buffer transfer. Each status register has its own read/write mask register. A status bit latches when its source fires and its mask bit is 1. The bit then stays set until a host read of that status register clears it. An active-high interrupt pin is the OR of every status bit.

A single mode input sets how sources are captured. In edge mode a bit latches on a rising edge of its source. In level mode a bit latches on every cycle the source is high, so a read cannot clear the bit while the source is still asserted. A mask bit of 0 blocks the status bit itself, not only the pin. If an event arrives in the same cycle as the clearing read, the event wins.

The host sees a flat register port with an address, a write enable, a read strobe, write data and read data. The read data is combinational from the address. A read strobe returns the value held before the clear, and the clear takes effect at the next clock edge.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset, or while rst_ni is low, every status and mask register reads 00h and irq_o is 0.
- R2: Address 07h returns status 0 and 08h returns status 1; both are read-only. Address 09h holds mask 0 and 0Ah holds mask 1; both are read/write. Any other address reads 00h.
- R3: Status 0 bit 7 is the slip flag. Status 1 bit 1 is the channel-status transfer flag and status 1 bit 2 is the user-data transfer flag. All other status bits always read 0. Each mask bit gates the status bit at the same position.
- R4: An unmasked event sets its status bit at the next clock edge. The bit then holds at 1 until its register is read.
- R5: A read of a status address returns the current value, and all bits of that register only are 0 from the next edge.
- R6: With level_mode_i=1, a bit whose source is high keeps setting. A read while the source is high leaves the bit at 1, and a read after the source drops clears it.
- R7: With level_mode_i=0, only a 0-to-1 source transition sets a bit. A source held high does not set the bit again after a clearing read.
- R8: A mask bit of 0 keeps its status bit at 0 and off irq_o. Clearing a mask bit clears a set status bit one edge after the mask write takes effect.
- R9: irq_o is registered and equals the OR of all status bits in every cycle.
- R10: An event that arrives in the same cycle as a clearing read of its register leaves its bit set.
- R11: Reading a mask register changes no state. Writes to status addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Register address |
| wr_en_i | input | 1 | Write enable for mask registers |
| rd_en_i | input | 1 | Read strobe; clears an addressed status register |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| level_mode_i | input | 1 | 1 = level capture, 0 = rising-edge capture |
| slip_evt_i | input | 1 | Source-sample slip event |
| cs_xfer_evt_i | input | 1 | Channel-status buffer transfer event |
| ud_xfer_evt_i | input | 1 | User-data buffer transfer event |
| irq_o | output | 1 | Active-high interrupt |

## Verification
The assertions check on every cycle that irq_o matches the OR of the status bits and that the unused status positions stay 0. They also check that a masked position never holds a 1 beyond the mask's one-edge lag and that a set, unread, unmasked bit holds. For the slip flag they check that level mode both sets and retains it, and that a level-mode read clears it once its source is low. The bench's scenarios are needed for the rest: the address map and mask readback, writes to status addresses being ignored, a read clearing only its own register, an event colliding with a clearing read, edge mode ignoring a held source, and reset in mid-run.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 8;
  localparam int NUM_REG   = 2;
  localparam int STAT_BASE = 'h07;  // status k at STAT_BASE + k
  localparam int MASK_BASE = 'h09;  // mask k at MASK_BASE + k
  localparam int SLIP_BIT  = 7;     // in status 0
  localparam int CS_BIT    = 1;     // in status 1
  localparam int UD_BIT    = 2;     // in status 1

  typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/irq_src_detect.sv
module irq_src_detect #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         level_mode_i,
  input  logic [W-1:0] src_i,
  output logic [W-1:0] hit_o
);
  logic [W-1:0] src_q;

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) src_q[b] <= 1'b0;
      else         src_q[b] <= src_i[b];
    end
    assign hit_o[b] = level_mode_i ? src_i[b] : (src_i[b] & ~src_q[b]);
  end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] hit_i,
  input  logic [W-1:0] mask_i,
  input  logic         clr_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] stat_nxt_o
);
  logic [W-1:0] stat_q;

  // event beats clear; mask forces zero
  assign stat_nxt_o = mask_i & (hit_i | (stat_q & {W{~clr_i}}));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= stat_nxt_o;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/irq_reg_if.sv
module irq_reg_if
  import irq_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int NR = NUM_REG
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [AW-1:0]         addr_i,
  input  logic                  wr_en_i,
  input  logic                  rd_en_i,
  input  logic [DW-1:0]         wdata_i,
  input  logic [NR-1:0][DW-1:0] stat_i,
  output logic [NR-1:0][DW-1:0] mask_o,
  output logic [NR-1:0]         clr_o,
  output logic [DW-1:0]         rdata_o
);
  logic [NR-1:0] stat_sel, mask_sel;
  logic [NR-1:0][DW-1:0] mask_q;

  for (genvar k = 0; k < NR; k++) begin : g_reg
    assign stat_sel[k] = (addr_i == AW'(STAT_BASE + k));
    assign mask_sel[k] = (addr_i == AW'(MASK_BASE + k));
    assign clr_o[k]    = rd_en_i & stat_sel[k];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    mask_q[k] <= '0;
      else if (wr_en_i && mask_sel[k]) mask_q[k] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NR; k++) begin
      if (stat_sel[k]) rdata_o = stat_i[k];
      if (mask_sel[k]) rdata_o = mask_q[k];
    end
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              level_mode_i,
  input  logic              slip_evt_i,
  input  logic              cs_xfer_evt_i,
  input  logic              ud_xfer_evt_i,
  output logic              irq_o
);
  logic [NUM_REG-1:0][DATA_W-1:0] src_vec, hit_vec, stat_q, stat_nxt, mask_q;
  logic [NUM_REG-1:0]             clr;
  logic                           irq_q;

  always_comb begin
    src_vec              = '0;
    src_vec[0][SLIP_BIT] = slip_evt_i;
    src_vec[1][CS_BIT]   = cs_xfer_evt_i;
    src_vec[1][UD_BIT]   = ud_xfer_evt_i;
  end

  irq_reg_if i_reg_if (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .wr_en_i (wr_en_i),
    .rd_en_i (rd_en_i),
    .wdata_i (wdata_i),
    .stat_i  (stat_q),
    .mask_o  (mask_q),
    .clr_o   (clr),
    .rdata_o (rdata_o)
  );

  for (genvar k = 0; k < NUM_REG; k++) begin : g_bank
    irq_src_detect #(.W(DATA_W)) i_det (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .level_mode_i (level_mode_i),
      .src_i        (src_vec[k]),
      .hit_o        (hit_vec[k])
    );

    irq_status_bank #(.W(DATA_W)) i_stat (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .hit_i      (hit_vec[k]),
      .mask_i     (mask_q[k]),
      .clr_i      (clr[k]),
      .stat_o     (stat_q[k]),
      .stat_nxt_o (stat_nxt[k])
    );
  end

  // registered from next state so the pin tracks the status registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |stat_nxt;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk
  import irq_pkg::*;
(
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic [ADDR_W-1:0]              addr_i,
  input logic                           rd_en_i,
  input logic                           level_mode_i,
  input logic                           slip_evt_i,
  input logic                           irq_o,
  input logic [NUM_REG-1:0][DATA_W-1:0] stat_q,
  input logic [NUM_REG-1:0][DATA_W-1:0] mask_q
);
  logic rd_stat0;
  assign rd_stat0 = rd_en_i && (addr_i == ADDR_W'(STAT_BASE));

  p_irq_or_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (|stat_q));

  p_unused_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q[0][SLIP_BIT-1:0] == '0) && (stat_q[1][DATA_W-1:UD_BIT+1] == '0)
    && (stat_q[1][0] == 1'b0));

  for (genvar k = 0; k < NUM_REG; k++) begin : g_mask
    p_mask_blocks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> ((stat_q[k] & ~$past(mask_q[k])) == '0));
  end

  p_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_q[0][SLIP_BIT] && mask_q[0][SLIP_BIT] && !rd_stat0 |=> stat_q[0][SLIP_BIT]);

  p_level_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_mode_i && slip_evt_i && mask_q[0][SLIP_BIT] |=> stat_q[0][SLIP_BIT]);

  p_level_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_mode_i && rd_stat0 && !slip_evt_i |=> !stat_q[0][SLIP_BIT]);
endmodule

bind irq_status_ctrl irq_status_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .addr_i       (addr_i),
  .rd_en_i      (rd_en_i),
  .level_mode_i (level_mode_i),
  .slip_evt_i   (slip_evt_i),
  .irq_o        (irq_o),
  .stat_q       (stat_q),
  .mask_q       (mask_q)
);

// File: tb/test_irq_status_ctrl.sv
module test_irq_status_ctrl;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic [7:0] addr_i = '0, wdata_i = '0;
  logic       wr_en_i = 1'b0, rd_en_i = 1'b0, level_mode_i = 1'b0;
  logic       slip_evt_i = 1'b0, cs_xfer_evt_i = 1'b0, ud_xfer_evt_i = 1'b0;
  logic [7:0] rdata_o;
  logic       irq_o;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #5 clk_i = ~clk_i;

  irq_status_ctrl i_irq_status_ctrl (.*);

  // addr, wr, rd, wdata, lvl, slip, cs, ud, exp_rdata, exp_irq, req
  typedef struct packed {
    logic [7:0] addr; logic wr; logic rd; logic [7:0] wdata;
    logic lvl; logic slip; logic cs; logic ud;
    logic [7:0] exp; logic irq; logic [7:0] req;
  } vec_t;

  localparam int NV = 35;
  localparam vec_t VECS [NV] = '{
    '{8'h09,1'b0,1'b1,8'h00,1'b0,1'b0,1'b0,1'b0,8'h00,1'b0,8'd1},  // R1
    '{8'h09,1'b1,1'b0,8'h80,1'b0,1'b0,1'b0,1'b0,8'h00,1'b0,8'd2},  // R2
    '{8'h0A,1'b1,1'b0,8'h06,1'b0,1'b0,1'b0,1'b0,8'h00,1'b0,8'd2},
    '{8'h09,1'b0,1'b1,8'h00,1'b0,1'b0,1'b0,1'b0,8'h80,1'b0,8'd11}, // R11
    '{8'h0A,1'b0,1'b1,8'h00,1'b0,1'b0,1'b0,1'b0,8'h06,1'b0,8'd2},
    '{8'h07,1'b0,1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,8'h00,1'b0,8'd4},  // R4
    '{8'h07,1'b0,1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,8'h80,1'b1,8'd4},
    '{8'h07,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,8'h80,1'b1,8'd4},
    '{8'h07,1'b0,1'b1,8'h00,1'b0,1'b0,1'b0,1'b0,8'h80,1'b1,8'd5},  // R5
    '{8'h07,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,8'h00,1'b0,8'd5},
    '{8'h08,1'b0,1'b0,8'h00,1'b0,1'b0,1'b1,1'b0,8'h00,1'b0,8'd3},  // R3
    '{8'h08,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b1,8'h02,1'b1,8'd3},
    '{8'h08,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,8'h06,1'b1,8'd3},
    '{8'h07,1'b0,1'b1,8'h00,1'b0,1'b0,1'b0,1'b0,8'h00,1'b1,8'd5},
    '{8'h08,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,8'h06,1'b1,8'd5},
    '{8'h08,1'b1,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,8'h06,1'b1,8'd11},
    '{8'h07,1'b1,1'b0,8'hFF,1'b0,1'b0,1'b0,1'b0,8'h00,1'b1,8'd11},
    '{8'h08,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,8'h06,1'b1,8'd11},
    '{8'h08,1'b0,1'b1,8'h00,1'b0,1'b0,1'b1,1'b0,8'h06,1'b1,8'd10}, // R10
    '{8'h08,1'b0,1'b0,8'h00,1'b0,1'b0,1'b1,1'b0,8'h02,1'b1,8'd10},
    '{8'h08,1'b0,1'b1,8'h00,1'b0,1'b0,1'b1,1'b0,8'h02,1'b1,8'd7},  // R7
    '{8'h08,1'b0,1'b0,8'h00,1'b0,1'b0,1'b1,1'b0,8'h00,1'b0,8'd7},
    '{8'h07,1'b0,1'b0,8'h00,1'b1,1'b1,1'b0,1'b0,8'h00,1'b0,8'd6},  // R6
    '{8'h07,1'b0,1'b1,8'h00,1'b1,1'b1,1'b0,1'b0,8'h80,1'b1,8'd6},
    '{8'h07,1'b0,1'b0,8'h00,1'b1,1'b1,1'b0,1'b0,8'h80,1'b1,8'd6},
    '{8'h07,1'b0,1'b1,8'h00,1'b1,1'b0,1'b0,1'b0,8'h80,1'b1,8'd6},
    '{8'h07,1'b0,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0,8'h00,1'b0,8'd6},
    '{8'h0A,1'b1,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,8'h06,1'b0,8'd8},  // R8
    '{8'h08,1'b0,1'b0,8'h00,1'b0,1'b0,1'b1,1'b1,8'h00,1'b0,8'd8},
    '{8'h08,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,8'h00,1'b0,8'd8},
    '{8'h07,1'b0,1'b0,8'h00,1'b0,1'b1,1'b0,1'b0,8'h00,1'b0,8'd8},
    '{8'h09,1'b1,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,8'h80,1'b1,8'd8},
    '{8'h07,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,8'h80,1'b1,8'd8},
    '{8'h07,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,8'h00,1'b0,8'd8},
    '{8'h0B,1'b0,1'b1,8'h00,1'b0,1'b0,1'b0,1'b0,8'h00,1'b0,8'd2}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    addr_i = v.addr; wr_en_i = v.wr; rd_en_i = v.rd; wdata_i = v.wdata;
    level_mode_i = v.lvl; slip_evt_i = v.slip; cs_xfer_evt_i = v.cs; ud_xfer_evt_i = v.ud;
  endtask

  task automatic idle();
    wr_en_i = 1'b0; rd_en_i = 1'b0; slip_evt_i = 1'b0;
    cs_xfer_evt_i = 1'b0; ud_xfer_evt_i = 1'b0; level_mode_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    #1;
    addr_i = 8'h07;
    check("R1 stat0 in reset", rdata_o, 8'h00);
    check("R1 irq in reset", {7'b0, irq_o}, 8'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      drive(VECS[i]);
      #1;
      check($sformatf("R%0d vec %0d rdata", VECS[i].req, i), rdata_o, VECS[i].exp);
      check($sformatf("R%0d vec %0d irq", VECS[i].req, i), {7'b0, irq_o}, {7'b0, VECS[i].irq});
    end

    // directed: reset in mid-run clears masks, status and pin (R1)
    @(negedge clk_i); idle(); addr_i = 8'h09; wr_en_i = 1'b1; wdata_i = 8'h80;
    @(negedge clk_i); wr_en_i = 1'b0; slip_evt_i = 1'b1;
    @(negedge clk_i); slip_evt_i = 1'b0; addr_i = 8'h07; #1;
    check("R4 slip set before reset", rdata_o, 8'h80);
    check("R9 irq before reset", {7'b0, irq_o}, 8'h01);
    rst_ni = 1'b0; #1;
    check("R1 irq during reset", {7'b0, irq_o}, 8'h00);
    check("R1 stat0 during reset", rdata_o, 8'h00);
    addr_i = 8'h09; #1;
    check("R1 mask0 during reset", rdata_o, 8'h00);
    @(negedge clk_i); rst_ni = 1'b1;

    // directed: masked slip never reaches status (R8)
    @(negedge clk_i); slip_evt_i = 1'b1; addr_i = 8'h07;
    @(negedge clk_i); slip_evt_i = 1'b0; #1;
    check("R8 masked slip status", rdata_o, 8'h00);
    check("R8 masked slip irq", {7'b0, irq_o}, 8'h00);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule